// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Write Gate

This block is a byte-addressed memory that answers on a two-wire serial bus. The bus master frames each transfer with START and STOP. It sends an address byte that selects this device and picks the direction. A write then carries a word address and up to a page of data bytes. A read returns bytes from the internal address pointer, one after another. The open-drain data line is modelled as a sampled input `sdaIn` and a pull-down enable `sdaOe`. Both bus lines are sampled on the system clock, so the bus must run well below that clock.

Write data is collected in a small page buffer. A STOP that closes a write starts a self-timed program cycle. When that cycle ends, the buffered bytes reach the array. The `wrEnable` input is sampled at that STOP. If it is low, the buffered bytes are thrown away. The word-address phase still works when `wrEnable` is low, so a random read can always aim the pointer. Once a program cycle has begun, it always runs to completion.

Top module: `twowire_eeprom_wp`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before the first START, and after any byte it rejects, the slave ignores all bus traffic until the next START and never pulls SDA low.
- R2: The address byte after START is accepted only when bits 7:4 equal 4'b1010. Bits 3:1 are don't-care. An accepted address byte is acknowledged by pulling SDA low during the ninth clock. Any other value gets no acknowledge.
- R3: Bit 0 of the address byte selects the direction: 0 means write or word-address setup, 1 means read.
- R4: In a write, the byte after the address byte is the word address. Its bits 6:0 load the pointer and bit 7 is ignored. The slave acknowledges the word address and every data byte that follows.
- R5: Data bytes go into an 8-entry page buffer at pointer bits 2:0. Those three bits then increment modulo 8, and pointer bits 6:3 stay fixed.
- R6: When a STOP closes a write that holds at least one data byte, and `wrEnable` is high at that STOP, a program cycle runs for PROG_CYCLES clocks. After it ends, the buffered bytes read back from the array.
- R7: If `wrEnable` is low at that STOP, no array byte changes and no program cycle starts. The word-address byte is still accepted and loads the pointer, so a random read returns the addressed byte.
- R8: Taking `wrEnable` low after a program cycle has started does not stop that cycle or its commit.
- R9: While a program cycle runs, the address byte gets no acknowledge.
- R10: Read data is sent MSB first from the byte at the pointer. The pointer then increments and wraps from 127 to 0. A master acknowledge requests the next byte. A master no-acknowledge makes the slave release SDA and go idle.
- R11: Only STOP commits. A repeated START during a write throws away the buffered data. A write-direction header followed by a repeated START and a read header gives a random read from the loaded pointer.
- R12: After reset and after every STOP, the slave leaves SDA released (`sdaOe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock as sampled |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaOe | output | 1 | Drive SDA low when 1, release when 0 |
| wrEnable | input | 1 | High allows array commits, low blocks them |

## Verification
A wrong pointer shows up at the ports on the next read, as a byte taken from the wrong place. A wrong page-slot index shows up only after the program cycle ends, when a read-back finds a byte in the wrong cell of the page. A wrong decision at STOP has two possible signs: an address acknowledged during what should be a busy window, or one refused when no cycle should be running. Either shows within one address byte of the STOP. A protocol state that is out of step with the bus shows on the next ninth clock, as a missing or extra acknowledge, or as SDA held low that blocks the next STOP.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACKDEV,
    ST_WORD,
    ST_ACKWORD,
    ST_WDATA,
    ST_ACKWR,
    ST_RDATA,
    ST_RACK
  } busState_e;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic shiftIn;    // sample one received bit
    logic loadPtr;    // word address complete
    logic pageWrite;  // data byte complete
    logic loadTx;     // fetch byte at pointer for transmit
    logic shiftTx;    // advance transmit bit
    logic startSeen;  // START or repeated START
    logic stopSeen;   // STOP
  } ctrlStrobe_t;

endpackage

// File: rtl/twe_ctrl.sv
module twe_ctrl
  import twe_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scl,
  input  logic        sdaIn,
  input  logic [7:0]  rxByte,
  input  logic        txMsb,
  input  logic        busy,
  output ctrlStrobe_t stb,
  output logic        sdaOe,
  output busState_e   busState
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic sclQ, sdaQ;
  logic sclRise, sclFall, startCond, stopCond;
  logic devMatch;

  busState_e   state, nState;
  logic [3:0]  bitCnt, nBit;
  logic        isRead, nRead;
  logic        masterAck, nMack;

  assign sclRise   =  scl & ~sclQ;
  assign sclFall   = ~scl &  sclQ;
  assign startCond =  scl &  sclQ &  sdaQ & ~sdaIn;
  assign stopCond  =  scl &  sclQ & ~sdaQ &  sdaIn;
  assign devMatch  = (rxByte[7:4] == DEV_ID) & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      sclQ      <= scl;
      sdaQ      <= sdaIn;
      state     <= nState;
      bitCnt    <= nBit;
      isRead    <= nRead;
      masterAck <= nMack;
    end
  end

  always_comb begin
    nState = state;
    nBit   = bitCnt;
    nRead  = isRead;
    nMack  = masterAck;
    stb    = '0;
    if (startCond) begin
      nState        = ST_DEV;
      nBit          = '0;
      stb.startSeen = 1'b1;
    end else if (stopCond) begin
      nState        = ST_IDLE;
      stb.stopSeen  = 1'b1;
    end else begin
      unique case (state)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            nBit        = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            nBit = '0;
            if (state == ST_DEV) begin
              if (devMatch) begin
                nState = ST_ACKDEV;
                nRead  = rxByte[0];
              end else begin
                nState = ST_IDLE;
              end
            end else if (state == ST_WORD) begin
              stb.loadPtr = 1'b1;
              nState      = ST_ACKWORD;
            end else begin
              stb.pageWrite = 1'b1;
              nState        = ST_ACKWR;
            end
          end
        end
        ST_ACKDEV: begin
          if (sclFall) begin
            if (isRead) begin
              stb.loadTx = 1'b1;
              nState     = ST_RDATA;
            end else begin
              nState = ST_WORD;
            end
          end
        end
        ST_ACKWORD, ST_ACKWR: begin
          if (sclFall) nState = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclRise) begin
            nBit = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == BITS_PER_BYTE) begin
              nBit   = '0;
              nState = ST_RACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            nMack = ~sdaIn;
          end else if (sclFall) begin
            if (masterAck) begin
              stb.loadTx = 1'b1;
              nState     = ST_RDATA;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ACKDEV, ST_ACKWORD, ST_ACKWR: sdaOe = 1'b1;
      ST_RDATA:                        sdaOe = ~txMsb;
      default:                         sdaOe = 1'b0;
    endcase
  end

  assign busState = state;

endmodule

// File: rtl/twe_data.sv
module twe_data
  import twe_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  input  logic        sdaBit,
  input  logic        wrEnable,
  output logic [7:0]  rxByte,
  output logic        txMsb,
  output logic        busy
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_SLOTS = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  logic [7:0]             mem [DEPTH];
  logic [7:0]             rxShift, txShift;
  logic [ADDR_W-1:0]      ptr;
  logic [PAGE_W-1:0]      slot;
  logic [BASE_W-1:0]      commitBase;
  logic [CNT_W-1:0]       busyCnt;
  logic [PAGE_SLOTS*8-1:0] pageFlat;
  logic [PAGE_SLOTS-1:0]  pageValid;
  logic                   pagePending, launch, discard, commitNow;

  assign slot        = ptr[PAGE_W-1:0];
  assign busy        = (busyCnt != '0);
  assign commitNow   = (busyCnt == CNT_W'(1));
  assign pagePending = |pageValid;
  // write gate: sampled once, at the STOP that closes a write
  assign launch      = stb.stopSeen & ~busy & pagePending &  wrEnable;
  assign discard     = (stb.stopSeen & ~busy & pagePending & ~wrEnable)
                     | (stb.startSeen & ~busy);

  // page buffer slots
  for (genvar s = 0; s < PAGE_SLOTS; s++) begin : g_slot
    logic [7:0] slotData;
    logic       slotValid;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotData  <= '0;
        slotValid <= 1'b0;
      end else if (stb.pageWrite && slot == PAGE_W'(s)) begin
        slotData  <= rxShift;
        slotValid <= 1'b1;
      end else if (commitNow || discard) begin
        slotValid <= 1'b0;
      end
    end
    assign pageFlat[s*8 +: 8] = slotData;
    assign pageValid[s]       = slotValid;
  end

  // shift registers and pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (stb.loadTx)       txShift <= mem[ptr];
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (stb.loadPtr)        ptr <= rxShift[ADDR_W-1:0];
      else if (stb.pageWrite) ptr <= {ptr[ADDR_W-1:PAGE_W], slot + 1'b1};
      else if (stb.loadTx)    ptr <= ptr + 1'b1;
    end
  end

  // self-timed program cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt    <= '0;
      commitBase <= '0;
    end else if (launch) begin
      busyCnt    <= CNT_W'(PROG_CYCLES);
      commitBase <= ptr[ADDR_W-1:PAGE_W];
    end else if (busy) begin
      busyCnt    <= busyCnt - 1'b1;
    end
  end

  // array, written only at the end of a program cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commitNow) begin
      for (int i = 0; i < PAGE_SLOTS; i++) begin
        if (pageValid[i]) mem[{commitBase, PAGE_W'(i)}] <= pageFlat[i*8 +: 8];
      end
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

endmodule

// File: rtl/twowire_eeprom_wp.sv
module twowire_eeprom_wp
  import twe_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_W      = 3,
  parameter int         PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic wrEnable
);

  ctrlStrobe_t stb;
  busState_e   busState;
  logic [7:0]  rxByte;
  logic        txMsb;
  logic        busy;

  twe_ctrl #(.DEV_ID(DEV_ID)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (scl),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .busy     (busy),
    .stb      (stb),
    .sdaOe    (sdaOe),
    .busState (busState)
  );

  twe_data #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sdaBit   (sdaIn),
    .wrEnable (wrEnable),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .busy     (busy)
  );

endmodule

// File: rtl/twowire_eeprom_wp_chk.sv
module twowire_eeprom_wp_chk
  import twe_pkg::*;
#(
  parameter int PROG_CYCLES = 200
) (
  input logic      clk,
  input logic      rstN,
  input logic      scl,
  input logic      sdaIn,
  input logic      sdaOe,
  input logic      wrEnable,
  input logic      busy,
  input busState_e busState
);

  localparam int RUN_W = $clog2(PROG_CYCLES + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // program cycle is entered only with the write gate open at STOP
  assert_commit_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEnable));

  // a started program cycle always runs its full length
  assert_cycle_not_aborted_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RUN_W'(PROG_CYCLES)));

  // no address acknowledge during a program cycle
  assert_nack_when_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_ACKDEV) |-> !busy);

  // slave never moves SDA while SCL stays high
  assert_sda_still_scl_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl)) |-> $stable(sdaOe));

  // SDA released right after any STOP
  assert_release_after_stop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl) && sdaIn && !$past(sdaIn)) |=> !sdaOe);

endmodule

bind twowire_eeprom_wp twowire_eeprom_wp_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .scl      (scl),
  .sdaIn    (sdaIn),
  .sdaOe    (sdaOe),
  .wrEnable (wrEnable),
  .busy     (busy),
  .busState (busState)
);

// File: tb/twowire_eeprom_wp_tb_top.sv
module twowire_eeprom_wp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int PROG       = 200;

  logic clk = 1'b0;
  logic rstN, sclDrv, masterSda, wrEnable;
  logic sdaOe, sdaLine;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] model [128];
  logic [7:0] wbuf  [8];
  int         benchPtr = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] gotQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine = sdaOe ? 1'b0 : masterSda;

  twowire_eeprom_wp #(.PROG_CYCLES(PROG)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (sclDrv),
    .sdaIn    (sdaLine),
    .sdaOe    (sdaOe),
    .wrEnable (wrEnable)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    masterSda = 1'b1; halfWait();
    sclDrv    = 1'b1; halfWait();
    masterSda = 1'b0; halfWait();
    sclDrv    = 1'b0; halfWait();
  endtask

  task automatic busStop();
    masterSda = 1'b0; halfWait();
    sclDrv    = 1'b1; halfWait();
    masterSda = 1'b1; halfWait();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      masterSda = b[i]; halfWait();
      sclDrv    = 1'b1; halfWait();
      sclDrv    = 1'b0;
    end
    masterSda = 1'b1; halfWait();
    sclDrv    = 1'b1; halfWait();
    acked     = (sdaLine == 1'b0);
    sclDrv    = 1'b0; halfWait();
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] d);
    masterSda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      halfWait();
      sclDrv = 1'b1; halfWait();
      d      = {d[6:0], sdaLine};
      sclDrv = 1'b0;
    end
    masterSda = mack ? 1'b0 : 1'b1; halfWait();
    sclDrv    = 1'b1; halfWait();
    sclDrv    = 1'b0; halfWait();
    masterSda = 1'b1;
  endtask

  // write sequence: header, word address, n data bytes, STOP
  task automatic doWrite(input logic [7:0] devByte, input logic [7:0] word,
                         input int n, input bit commits);
    bit ack;
    busStart();
    sendByte(devByte, ack);
    check(ack, "R2 address ack on write header", ack, 1);
    sendByte(word, ack);
    check(ack, "R4 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      check(ack, "R4 data byte ack", ack, 1);
    end
    busStop();
    for (int i = 0; i < n; i++) begin
      if (commits) model[{word[6:3], 3'(word[2:0] + 3'(i))}] = wbuf[i];
    end
    benchPtr = {word[6:3], 3'(word[2:0] + 3'(n))};
  endtask

  // optional word-address setup, then n reads, last one NACKed
  task automatic doRead(input logic [7:0] word, input bit useWord, input int n,
                        input string tag);
    bit ack;
    logic [7:0] d;
    busStart();
    if (useWord) begin
      sendByte(8'hA0, ack);
      check(ack, "R3 write header for random read", ack, 1);
      sendByte(word, ack);
      check(ack, "R7 word address ack", ack, 1);
      benchPtr = int'(word[6:0]);
      busStart();
    end
    sendByte(8'hA1, ack);
    check(ack, "R3 read header ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(model[benchPtr]);
      tagQ.push_back(tag);
      benchPtr = (benchPtr + 1) % 128;
      recvByte(i < n - 1, d);
      gotQ.push_back(d);
    end
    check(sdaOe == 1'b0, "R10 release after master NACK", sdaOe, 0);
    busStop();
    check(sdaOe == 1'b0, "R12 released after STOP", sdaOe, 0);
  endtask

  task automatic waitProg();
    repeat (PROG + 20) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    masterSda = 1'b1;
    sclDrv    = 1'b1;
    wrEnable  = 1'b1;
    rstN      = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    halfWait();
    check(sdaOe == 1'b0, "R12 reset leaves SDA released", sdaOe, 0);

    // R1: matching byte clocked without START is ignored
    sendByte(8'hA0, ack);
    check(!ack, "R1 no ack before START", ack, 0);
    busStop();

    // R2: wrong device id, then further bytes ignored until START
    busStart();
    sendByte(8'hB0, ack);
    check(!ack, "R2 wrong id not acked", ack, 0);
    sendByte(8'hA0, ack);
    check(!ack, "R1 ignored until next START", ack, 0);
    busStop();

    // R6 write with don't-care bits set, then R9 busy poll
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    doWrite(8'hAE, 8'h10, 3, 1'b1);
    busStart();
    sendByte(8'hA0, ack);
    check(!ack, "R9 no ack during program cycle", ack, 0);
    busStop();
    waitProg();
    doRead(8'h10, 1'b1, 3, "R6 R10 sequential read after commit");
    doRead(8'h90, 1'b1, 1, "R4 word address bit 7 ignored");

    // R5 page wrap
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    doWrite(8'hA0, 8'h1E, 3, 1'b1);
    waitProg();
    doRead(8'h18, 1'b1, 1, "R5 third byte wrapped to page start");
    doRead(8'h1E, 1'b1, 3, "R5 page wrap leaves next page untouched");

    // R7 write gate closed at STOP
    wrEnable = 1'b0;
    wbuf[0] = 8'h55;
    doWrite(8'hA0, 8'h40, 1, 1'b0);
    busStart();
    sendByte(8'hA0, ack);
    check(ack, "R7 no program cycle when gate closed", ack, 1);
    busStop();
    doRead(8'h40, 1'b1, 1, "R7 array unchanged, random read with gate low");
    wrEnable = 1'b1;

    // R8 gate drops during program cycle
    wbuf[0] = 8'h77;
    doWrite(8'hA0, 8'h50, 1, 1'b1);
    repeat (10) @(negedge clk);
    wrEnable = 1'b0;
    waitProg();
    doRead(8'h50, 1'b1, 1, "R8 commit completes after gate drop");
    wrEnable = 1'b1;

    // R10 pointer wrap 127 -> 0, then current-address read
    wbuf[0] = 8'h9A;
    doWrite(8'hA0, 8'h7F, 1, 1'b1);
    waitProg();
    wbuf[0] = 8'h5C;
    doWrite(8'hA0, 8'h00, 1, 1'b1);
    waitProg();
    doRead(8'h7F, 1'b1, 2, "R10 read wraps from 127 to 0");
    doRead(8'h00, 1'b0, 1, "R10 current address read continues");

    // R11 repeated START abandons buffered write
    busStart();
    sendByte(8'hA0, ack);
    check(ack, "R11 header ack", ack, 1);
    sendByte(8'h60, ack);
    check(ack, "R11 word ack", ack, 1);
    sendByte(8'h44, ack);
    check(ack, "R11 data ack", ack, 1);
    busStart();
    sendByte(8'hA1, ack);
    check(ack, "R11 read after repeated START acked", ack, 1);
    recvByte(1'b0, d);
    check(d == model[8'h61], "R11 read from pointer after one data byte", d, model[8'h61]);
    busStop();
    busStart();
    sendByte(8'hA0, ack);
    check(ack, "R11 no program cycle after abandoned write", ack, 1);
    busStop();
    doRead(8'h60, 1'b1, 1, "R11 abandoned byte never committed");

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R10 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule